// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This unit sits in the execute stage of an instruction pipeline. It takes the opcode bytes of a decoded conditional relative jump and decides whether the jump is taken. To do that it uses the current arithmetic status flags, or the count register for the counter-zero form. It then produces the instruction pointer to fetch from next. The operand-size attribute sets the width of the displacement for the two-byte form and controls truncation of the taken target. The address-size attribute sets how many bits of the count register are tested.

Each request is presented for one cycle with `in_valid`. The verdict appears on the registered result ports one clock later, together with a one-cycle `res_valid` strobe. A taken target above the supplied segment limit is reported as a protection fault, and the pointer is left at its previous value. An opcode outside the supported forms is reported as invalid and also leaves the pointer untouched. Between requests, every result port except the strobe holds its last value.

Top module: `branch_cond_eval`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R2: A first byte in 70h..7Fh is the short form. Its displacement is `disp[7:0]`, sign-extended.
- R3: A first byte of 0Fh followed by a second byte in 80h..8Fh is the near form. Its displacement is `disp[15:0]`, sign-extended, when `opsize_32`=0, and all of `disp[31:0]` when `opsize_32`=1.
- R4: The low nibble of the condition byte selects the predicate. The condition byte is the first byte for the short form and the second byte for the near form. Flag positions are `status_flags[0]`=carry, [1]=parity, [2]=zero, [3]=sign and [4]=overflow. The predicates by nibble are:
  - 0/1: overflow set / clear
  - 2/3: carry set / clear
  - 4/5: zero set / clear
  - 6: carry or zero; 7: neither carry nor zero
  - 8/9: sign set / clear
  - A/B: parity set / clear
  - C: sign differs from overflow; D: sign equals overflow
  - E: zero, or sign differs from overflow; F: zero clear and sign equals overflow
- R5: First byte E3h is the counter-zero form. It ignores the flags and uses `disp[7:0]` sign-extended. It is taken when `count_val[15:0]` is zero with `addrsize_32`=0, and when all 32 bits are zero with `addrsize_32`=1.
- R6: A taken jump targets `next_ip` plus the sign-extended displacement, modulo 2^32. When `opsize_32`=0 the upper 16 bits of the target are cleared.
- R7: A jump that is not taken sets `res_ip` to `next_ip`, unmodified.
- R8: A taken jump whose target is above `seg_limit` (unsigned) sets `res_gp_fault`=1 and `res_taken`=1, and `res_ip` keeps its previous value. A target equal to the limit does not fault.
- R9: Any other opcode sets `res_bad_op`=1, `res_taken`=0 and `res_gp_fault`=0, and `res_ip` keeps its previous value.
- R10: After reset every result port is zero.
- R11: Without `in_valid`, `res_taken`, `res_ip`, `res_gp_fault` and `res_bad_op` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte (used by the near form only) |
| status_flags | input | 5 | {overflow, sign, zero, parity, carry} |
| count_val | input | 32 | Count register value |
| opsize_32 | input | 1 | Operand size is 32 bits when high |
| addrsize_32 | input | 1 | Address size is 32 bits when high |
| next_ip | input | 32 | Address of the following instruction |
| disp | input | 32 | Raw displacement field |
| seg_limit | input | 32 | Code segment limit |
| res_valid | output | 1 | One-cycle result strobe |
| res_taken | output | 1 | Condition held |
| res_ip | output | 32 | Next instruction pointer |
| res_gp_fault | output | 1 | Taken target beyond the segment limit |
| res_bad_op | output | 1 | Unsupported opcode |

## Verification
Assertions check on every cycle the properties that relate signals over time. These are the strobe timing, the counter-zero decision for a zero count, the exclusivity of the fault and invalid results, the pointer holding on faults and invalid opcodes, and the upper-half clearing under a 16-bit operand size. Only the bench scenarios can show that each of the sixteen predicates reads the right flags, that displacement widths and signs are correct for each form, and that the boundary cases behave as required. Those boundary cases are a target exactly at the limit and a count that is zero in its low half only.

// File: rtl/bce_pkg.sv
// Shared types for the branch condition evaluator.
// Assumes a 5-bit flag vector laid out as the FLG_* positions below.
package bce_pkg;
    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_SHORT = 2'd1,
        FORM_NEAR  = 2'd2,
        FORM_CTRZ  = 2'd3
    } jform_t;

    localparam int FLAG_W  = 5;
    localparam int FLG_CY  = 0;
    localparam int FLG_PAR = 1;
    localparam int FLG_ZR  = 2;
    localparam int FLG_SG  = 3;
    localparam int FLG_OV  = 4;
endpackage

// File: rtl/bce_opdecode.sv
// Classifies the opcode bytes into a jump form and extracts the predicate
// selector nibble. Assumes the bytes are already aligned by the decoder.
module bce_opdecode
    import bce_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte0,
    input  logic [BYTE_W-1:0] byte1,
    output jform_t            form,
    output logic [3:0]        sel
);
    localparam logic [BYTE_W-1:0] ESC_BYTE  = BYTE_W'(8'h0F);
    localparam logic [BYTE_W-1:0] CTRZ_BYTE = BYTE_W'(8'hE3);
    localparam logic [BYTE_W-5:0] SHORT_HI  = (BYTE_W-4)'(4'h7);
    localparam logic [BYTE_W-5:0] NEAR_HI   = (BYTE_W-4)'(4'h8);

    // Form classification from the byte pattern.
    always_comb begin
        form = FORM_NONE;
        sel  = byte0[3:0];
        if (byte0[BYTE_W-1:4] == SHORT_HI) begin
            form = FORM_SHORT;
        end else if (byte0 == ESC_BYTE && byte1[BYTE_W-1:4] == NEAR_HI) begin
            form = FORM_NEAR;
            sel  = byte1[3:0];
        end else if (byte0 == CTRZ_BYTE) begin
            form = FORM_CTRZ;
        end
    end
endmodule

// File: rtl/bce_flagpred.sv
// Evaluates one of sixteen flag predicates. Even selectors test a base
// condition, odd selectors its complement. Purely combinational.
module bce_flagpred
    import bce_pkg::*;
(
    input  logic [3:0]        sel,
    input  logic [FLAG_W-1:0] flags,
    output logic              hit
);
    logic cy, par, zr, sg, ov, sg_ne_ov;
    logic [7:0] base;

    // Name the individual flags.
    always_comb begin
        cy       = flags[FLG_CY];
        par      = flags[FLG_PAR];
        zr       = flags[FLG_ZR];
        sg       = flags[FLG_SG];
        ov       = flags[FLG_OV];
        sg_ne_ov = sg ^ ov;
    end

    // Base conditions indexed by selector bits [3:1].
    always_comb begin
        base[0] = ov;
        base[1] = cy;
        base[2] = zr;
        base[3] = cy | zr;
        base[4] = sg;
        base[5] = par;
        base[6] = sg_ne_ov;
        base[7] = zr | sg_ne_ov;
    end

    // Pick and optionally invert the base condition.
    always_comb begin
        hit = base[sel[3:1]] ^ sel[0];
    end
endmodule

// File: rtl/bce_ctrzero.sv
// Tests the count register for zero. The tested width is the narrow width
// or the full width, chosen by the address-size attribute.
module bce_ctrzero #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic             wide,
    output logic             is_zero
);
    logic low_zero;
    logic high_zero;

    // Split zero detection so the narrow mode skips the upper half.
    always_comb begin
        low_zero  = (count[NARROW_W-1:0] == '0);
        high_zero = (count[CNT_W-1:NARROW_W] == '0);
        is_zero   = low_zero & (high_zero | ~wide);
    end
endmodule

// File: rtl/bce_target.sv
// Sign-extends the displacement for the form, adds it to the following
// address, truncates for a narrow operand size and compares to the limit.
module bce_target
    import bce_pkg::*;
#(
    parameter int IP_W     = 32,
    parameter int NARROW_W = 16,
    parameter int SHORT_W  = 8
) (
    input  jform_t          form,
    input  logic            op_wide,
    input  logic [IP_W-1:0] next_ip,
    input  logic [IP_W-1:0] disp,
    input  logic [IP_W-1:0] limit,
    output logic [IP_W-1:0] target,
    output logic            beyond
);
    localparam int SHORT_PAD  = IP_W - SHORT_W;
    localparam int NARROW_PAD = IP_W - NARROW_W;

    logic [IP_W-1:0] ext_short;
    logic [IP_W-1:0] ext_narrow;
    logic [IP_W-1:0] offset;
    logic [IP_W-1:0] sum;

    // Displacement width depends on form and operand size.
    always_comb begin
        ext_short  = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        ext_narrow = {{NARROW_PAD{disp[NARROW_W-1]}}, disp[NARROW_W-1:0]};
        if (form == FORM_NEAR)
            offset = op_wide ? disp : ext_narrow;
        else
            offset = ext_short;
    end

    // Add, truncate and compare against the segment limit.
    always_comb begin
        sum = next_ip + offset;
        if (op_wide)
            target = sum;
        else
            target = {{NARROW_PAD{1'b0}}, sum[NARROW_W-1:0]};
        beyond = (target > limit);
    end
endmodule

// File: rtl/branch_cond_eval.sv
// Top of the conditional branch evaluator. It decodes the opcode, evaluates
// the flag or counter condition, computes the target and registers the
// verdict one cycle after in_valid. Assumes one request per valid cycle and
// no back-pressure.
module branch_cond_eval
    import bce_pkg::*;
#(
    parameter int IP_W     = 32,
    parameter int NARROW_W = 16,
    parameter int SHORT_W  = 8,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] op_byte0,
    input  logic [BYTE_W-1:0] op_byte1,
    input  logic [FLAG_W-1:0] status_flags,
    input  logic [IP_W-1:0]   count_val,
    input  logic              opsize_32,
    input  logic              addrsize_32,
    input  logic [IP_W-1:0]   next_ip,
    input  logic [IP_W-1:0]   disp,
    input  logic [IP_W-1:0]   seg_limit,
    output logic              res_valid,
    output logic              res_taken,
    output logic [IP_W-1:0]   res_ip,
    output logic              res_gp_fault,
    output logic              res_bad_op
);
    localparam logic [BYTE_W-1:0] CTRZ_OP = BYTE_W'(8'hE3);

    jform_t          form;
    logic [3:0]      sel;
    logic            flag_hit;
    logic            ctr_zero;
    logic            cond;
    logic [IP_W-1:0] target;
    logic            beyond;

    bce_opdecode #(.BYTE_W(BYTE_W)) u_dec (
        .byte0 (op_byte0),
        .byte1 (op_byte1),
        .form  (form),
        .sel   (sel)
    );

    bce_flagpred u_pred (
        .sel   (sel),
        .flags (status_flags),
        .hit   (flag_hit)
    );

    bce_ctrzero #(.CNT_W(IP_W), .NARROW_W(NARROW_W)) u_ctr (
        .count   (count_val),
        .wide    (addrsize_32),
        .is_zero (ctr_zero)
    );

    bce_target #(.IP_W(IP_W), .NARROW_W(NARROW_W), .SHORT_W(SHORT_W)) u_tgt (
        .form    (form),
        .op_wide (opsize_32),
        .next_ip (next_ip),
        .disp    (disp),
        .limit   (seg_limit),
        .target  (target),
        .beyond  (beyond)
    );

    // Choose the counter test or the flag predicate.
    always_comb begin
        cond = (form == FORM_CTRZ) ? ctr_zero : flag_hit;
    end

    // Register the verdict; the pointer moves only on a clean outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_taken    <= 1'b0;
            res_ip       <= '0;
            res_gp_fault <= 1'b0;
            res_bad_op   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                if (form == FORM_NONE) begin
                    res_taken    <= 1'b0;
                    res_gp_fault <= 1'b0;
                    res_bad_op   <= 1'b1;
                end else begin
                    res_taken    <= cond;
                    res_gp_fault <= cond & beyond;
                    res_bad_op   <= 1'b0;
                    if (!cond)
                        res_ip <= next_ip;
                    else if (!beyond)
                        res_ip <= target;
                end
            end
        end
    end

    // R1: strobe follows the request by exactly one cycle
    p_strobe_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    p_strobe_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    // R5: a fully zero count is taken regardless of flags and address size
    p_ctr_zero_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_byte0 == CTRZ_OP && count_val == '0) |=> res_taken);

    // R6: narrow operand size never yields an upper half on a taken target
    p_narrow_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opsize_32) |=>
            (!res_taken || res_gp_fault || res_ip[IP_W-1:NARROW_W] == '0));

    // R7: not-taken, supported requests pass the following address through
    p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_taken || res_bad_op || res_ip == $past(next_ip)));

    // R8: a fault is only reported on a taken jump, and the pointer holds
    p_fault_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_gp_fault |-> res_taken);
    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_gp_fault) |-> $stable(res_ip));

    // R9: an invalid opcode excludes taken and fault, and the pointer holds
    p_bad_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_bad_op |-> (!res_taken && !res_gp_fault));
    p_bad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_bad_op) |-> $stable(res_ip));

    // R11: results hold when no request arrived
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_ip) && $stable(res_taken)));
endmodule

// File: tb/branch_cond_eval_tb_top.sv
// Scoreboard bench: the driver computes the expected verdict from the
// requirements and queues it; the monitor compares on every result strobe.
module branch_cond_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_byte0 = '0;
    logic [7:0]  op_byte1 = '0;
    logic [4:0]  status_flags = '0;
    logic [31:0] count_val = '0;
    logic        opsize_32 = 1'b1;
    logic        addrsize_32 = 1'b1;
    logic [31:0] next_ip = '0;
    logic [31:0] disp = '0;
    logic [31:0] seg_limit = '1;
    logic        res_valid;
    logic        res_taken;
    logic [31:0] res_ip;
    logic        res_gp_fault;
    logic        res_bad_op;

    typedef struct {
        logic        taken;
        logic [31:0] ip;
        logic        fault;
        logic        bad;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model_ip = '0;
    logic        model_taken = 1'b0;
    int          cycles = 0;

    always #2 clk = ~clk;

    branch_cond_eval dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_byte0(op_byte0), .op_byte1(op_byte1), .status_flags(status_flags),
        .count_val(count_val), .opsize_32(opsize_32), .addrsize_32(addrsize_32),
        .next_ip(next_ip), .disp(disp), .seg_limit(seg_limit),
        .res_valid(res_valid), .res_taken(res_taken), .res_ip(res_ip),
        .res_gp_fault(res_gp_fault), .res_bad_op(res_bad_op)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Predicate per R4: carry[0] parity[1] zero[2] sign[3] overflow[4]
    function automatic logic pred(input logic [3:0] n, input logic [4:0] f);
        logic c, p, z, s, o;
        c = f[0]; p = f[1]; z = f[2]; s = f[3]; o = f[4];
        case (n)
            4'h0: return o == 1'b1;
            4'h1: return o == 1'b0;
            4'h2: return c == 1'b1;
            4'h3: return c == 1'b0;
            4'h4: return z == 1'b1;
            4'h5: return z == 1'b0;
            4'h6: return (c == 1'b1) || (z == 1'b1);
            4'h7: return (c == 1'b0) && (z == 1'b0);
            4'h8: return s == 1'b1;
            4'h9: return s == 1'b0;
            4'hA: return p == 1'b1;
            4'hB: return p == 1'b0;
            4'hC: return s != o;
            4'hD: return s == o;
            4'hE: return (z == 1'b1) || (s != o);
            default: return (z == 1'b0) && (s == o);
        endcase
    endfunction

    // Drive one request at a falling edge and queue its expectation.
    task automatic send(input string req, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [4:0] fl, input logic [31:0] cnt,
                        input logic os32, input logic as32, input logic [31:0] nip,
                        input logic [31:0] d, input logic [31:0] lim);
        exp_t        e;
        logic        supported;
        logic        cond;
        logic [31:0] off;
        logic [31:0] tgt;
        supported = 1'b1;
        cond = 1'b0;
        off = {{24{d[7]}}, d[7:0]};
        if (b0[7:4] == 4'h7) begin
            cond = pred(b0[3:0], fl);
        end else if (b0 == 8'h0F && b1[7:4] == 4'h8) begin
            cond = pred(b1[3:0], fl);
            off = os32 ? d : {{16{d[15]}}, d[15:0]};
        end else if (b0 == 8'hE3) begin
            cond = as32 ? (cnt == 32'd0) : (cnt[15:0] == 16'd0);
        end else begin
            supported = 1'b0;
        end
        tgt = nip + off;
        if (!os32) tgt[31:16] = 16'h0;
        e.req = req;
        if (!supported) begin
            e.taken = 1'b0; e.fault = 1'b0; e.bad = 1'b1; e.ip = model_ip;
        end else if (!cond) begin
            e.taken = 1'b0; e.fault = 1'b0; e.bad = 1'b0; e.ip = nip;
        end else if (tgt > lim) begin
            e.taken = 1'b1; e.fault = 1'b1; e.bad = 1'b0; e.ip = model_ip;
        end else begin
            e.taken = 1'b1; e.fault = 1'b0; e.bad = 1'b0; e.ip = tgt;
        end
        model_ip = e.ip;
        model_taken = e.taken;
        sb_q.push_back(e);
        op_byte0 = b0; op_byte1 = b1; status_flags = fl; count_val = cnt;
        opsize_32 = os32; addrsize_32 = as32; next_ip = nip; disp = d;
        seg_limit = lim; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each strobed result with the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check("R1", "unexpected strobe", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "taken", 32'(res_taken), 32'(e.taken));
                check(e.req, "ip", res_ip, e.ip);
                check(e.req, "fault", 32'(res_gp_fault), 32'(e.fault));
                check(e.req, "bad_op", 32'(res_bad_op), 32'(e.bad));
            end
        end
    end

    // Watchdog: a hung run is a failed check and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "valid", 32'(res_valid), 32'd0);
        check("R10", "taken", 32'(res_taken), 32'd0);
        check("R10", "ip", res_ip, 32'd0);
        check("R10", "fault", 32'(res_gp_fault), 32'd0);
        check("R10", "bad_op", 32'(res_bad_op), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: every short predicate against every flag pattern
        for (int n = 0; n < 16; n++) begin
            for (int f = 0; f < 32; f++) begin
                send("R4", 8'h70 | 8'(n), 8'h00, 5'(f), 32'd5, 1'b1, 1'b1,
                     32'h0000_1000 + 32'(f), 32'h0000_0080 + 32'(n), 32'hFFFF_FFFF);
            end
        end
        // R2: forward and backward short displacements
        send("R2", 8'h74, 8'h00, 5'b00100, 32'd0, 1'b1, 1'b1, 32'h0000_2000, 32'hFFFF_FF7F, 32'hFFFF_FFFF);
        send("R2", 8'h74, 8'h00, 5'b00100, 32'd0, 1'b1, 1'b1, 32'h0000_2000, 32'h0000_1180, 32'hFFFF_FFFF);

        // R3: near form, wide and narrow operand sizes, both signs
        send("R3", 8'h0F, 8'h85, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0010_0000, 32'h0002_0000, 32'hFFFF_FFFF);
        send("R3", 8'h0F, 8'h85, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0010_0000, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
        send("R3", 8'h0F, 8'h8F, 5'b11000, 32'd0, 1'b0, 1'b1, 32'h0000_0100, 32'h7777_8000, 32'hFFFF_FFFF);
        for (int n = 0; n < 16; n++) begin
            send("R4", 8'h0F, 8'h80 | 8'(n), 5'(n * 7), 32'd0, 1'b1, 1'b1,
                 32'h0000_4000, 32'h0000_0400, 32'hFFFF_FFFF);
        end

        // R6: narrow operand size clears the upper half of the target
        send("R6", 8'h0F, 8'h84, 5'b00100, 32'd0, 1'b0, 1'b1, 32'h1234_FFF0, 32'h0000_0020, 32'hFFFF_FFFF);
        send("R6", 8'h72, 8'h00, 5'b00001, 32'd0, 1'b0, 1'b1, 32'h0005_0010, 32'h0000_0004, 32'hFFFF_FFFF);
        // R7: not taken with narrow operand size keeps the full next address
        send("R7", 8'h72, 8'h00, 5'b00000, 32'd0, 1'b0, 1'b1, 32'h0005_0010, 32'h0000_0004, 32'hFFFF_FFFF);

        // R5: counter form, flags ignored, width per address size
        send("R5", 8'hE3, 8'h00, 5'b11111, 32'h0001_0000, 1'b1, 1'b0, 32'h0000_3000, 32'h0000_0010, 32'hFFFF_FFFF);
        send("R5", 8'hE3, 8'h00, 5'b00000, 32'h0001_0000, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_0010, 32'hFFFF_FFFF);
        send("R5", 8'hE3, 8'h00, 5'b10101, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_00F0, 32'hFFFF_FFFF);
        send("R5", 8'hE3, 8'h00, 5'b00000, 32'h0000_0001, 1'b1, 1'b0, 32'h0000_3000, 32'h0000_00F0, 32'hFFFF_FFFF);

        // R8: limit boundary, equal passes, one above faults
        send("R8", 8'h75, 8'h00, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0000_0100, 32'h0000_0010, 32'h0000_0110);
        send("R8", 8'h75, 8'h00, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0000_0100, 32'h0000_0011, 32'h0000_0110);
        send("R8", 8'h75, 8'h00, 5'b00100, 32'd0, 1'b1, 1'b1, 32'h0000_0900, 32'h0000_0011, 32'h0000_0110);

        // R9: unsupported opcodes leave the pointer alone
        send("R9", 8'h0F, 8'h75, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0000_7777, 32'h0000_0001, 32'hFFFF_FFFF);
        send("R9", 8'hE9, 8'h00, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0000_8888, 32'h0000_0001, 32'hFFFF_FFFF);
        send("R9", 8'h80, 8'h00, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0000_9999, 32'h0000_0001, 32'hFFFF_FFFF);

        // R11: idle cycles with changing inputs keep the results
        send("R11", 8'h7F, 8'h00, 5'b00000, 32'd0, 1'b1, 1'b1, 32'h0000_0A00, 32'h0000_0002, 32'hFFFF_FFFF);
        op_byte0 = 8'h74; status_flags = 5'b00100; next_ip = 32'hDEAD_0000;
        repeat (4) @(negedge clk);
        check("R11", "idle valid", 32'(res_valid), 32'd0);
        check("R11", "idle ip", res_ip, model_ip);
        check("R11", "idle taken", 32'(res_taken), 32'(model_taken));
        check("R1", "queue drained", 32'(sb_q.size()), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule